// File: doc/BRIEF.md
# Transmit Buffer with Watermark Request

This block is the holding queue in front of an asynchronous serial transmitter. Software pushes datawords into it one at a time through a single-cycle write strobe. The transmit shift register pulls words out through a request/valid handshake. When the shifter accepts a word, that word leaves the occupancy count at once. The count therefore covers only the words still waiting in the queue. Software can work out the free room as the depth minus the count.

A 2-bit threshold register sets a low-water mark. A registered request line, meant as an interrupt or DMA trigger, is high whenever the count is at or below that mark. A software refill loop can therefore top the queue up before it drains. The threshold must be programmed below the depth.

A one-cycle flush strobe empties the queue. It is a command input and has no stored state. A software reset input returns everything to its power-up state, exactly like the chip reset. Both resets are synchronous and active high. A single clock is used throughout.

Top module: `tx_wm_fifo`

## Requirements
- R1: A write with `wr_en`=1 to a queue holding fewer than DEPTH (default 4) words stores `wr_data` and raises `level` by one at that clock edge. Words leave in the order they were written.
- R2: When `pop_req`=1 and `level`>0, the oldest word is taken. `level` falls by one at that same edge. In the following cycle `pop_valid`=1 and `pop_data` holds the word.
- R3: A `pop_req` while `level`=0 is ignored: `pop_valid` stays 0 in the next cycle and `level` stays 0.
- R4: A write while `level`=DEPTH is dropped, whether or not a pop happens in the same cycle. `ovf` is 1 for exactly the next cycle, and the stored words are unchanged.
- R5: An accepted write and an accepted pop in the same cycle leave `level` unchanged.
- R6: `tx_req` is registered. After each edge it equals the result of (`level` <= `wm_q`) sampled just before that edge.
- R7: `wm_we`=1 loads the 2-bit `wm_wdata` into the threshold at the clock edge. `wm_q` reads it back.
- R8: `flush`=1 makes `level` 0 after the edge. It overrides a write and a pop in the same cycle: the written word is discarded, and `pop_valid` and `ovf` are 0 in the next cycle.
- R9: `rst` or `sw_rst` gives, after the edge: `level`=0, `wm_q`=0, `tx_req`=1, `ovf`=0 and `pop_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous chip reset, active high |
| sw_rst | input | 1 | Synchronous software reset, active high |
| wr_en | input | 1 | Write strobe from the bus |
| wr_data | input | DATA_W | Dataword to store |
| flush | input | 1 | Empty the queue (command strobe) |
| wm_we | input | 1 | Threshold write strobe |
| wm_wdata | input | WM_W | New threshold value |
| pop_req | input | 1 | Shifter asks for the next word |
| pop_valid | output | 1 | `pop_data` carries an accepted word |
| pop_data | output | DATA_W | Word handed to the shifter |
| level | output | CNT_W | Words waiting, excluding the one handed out |
| wm_q | output | WM_W | Threshold readback |
| tx_req | output | 1 | Interrupt / DMA request, count at or below threshold |
| ovf | output | 1 | One-cycle pulse on a dropped write |

## Verification
The hardest case to reach is the full queue seeing a write and a pop together, and flush arriving together with both. The bench reaches it by filling the queue to DEPTH, then stepping through these combinations. A reference model compares every output after every cycle. The bench also sweeps every threshold value against every fill level, up to one write past full. This covers each edge of the `tx_req` comparison and its one-cycle lag.

// File: rtl/txf_pkg.sv
package txf_pkg;
  localparam int DATA_W_DEF = 8;
  localparam int DEPTH_DEF  = 4;
  localparam int WM_W_DEF   = 2;

  function automatic int cnt_bits(input int depth);
    return $clog2(depth + 1);
  endfunction

  function automatic int addr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/txf_store.sv
module txf_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int AW     = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl #(
  parameter int DEPTH = 4,
  parameter int AW    = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic             re,
  output logic [AW-1:0]    raddr,
  output logic [CNT_W-1:0] level,
  output logic             pop_valid,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [AW-1:0]    LAST_PTR = AW'(DEPTH - 1);

  logic [AW-1:0]    wp, rp;
  logic [CNT_W-1:0] cnt;
  logic             full, empty, do_push, do_pop;

  assign full    = (cnt == FULL_CNT);
  assign empty   = (cnt == '0);
  assign do_push = push & ~flush & ~full;
  assign do_pop  = pop & ~flush & ~empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp        <= '0;
      rp        <= '0;
      cnt       <= '0;
      pop_valid <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      pop_valid <= do_pop;
      ovf       <= push & full;
    end
  end

  assign we    = do_push;
  assign waddr = wp;
  assign re    = do_pop;
  assign raddr = rp;
  assign level = cnt;

  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt <= FULL_CNT);
  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst) flush |=> (cnt == '0 && !pop_valid));
  // R5
  push_pop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !flush && !full && !empty) |=> $stable(cnt));
  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !flush && !pop) |=> (ovf && $stable(cnt)));
  // R3
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> !pop_valid);
  // R2
  pop_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !empty && !flush) |=> (pop_valid && cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/txf_wmark.sv
module txf_wmark #(
  parameter int WM_W  = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wm_we,
  input  logic [WM_W-1:0]  wm_wdata,
  input  logic [CNT_W-1:0] level,
  output logic [WM_W-1:0]  wm_q,
  output logic             req
);
  logic at_or_below;
  assign at_or_below = ({{(CNT_W > WM_W ? CNT_W - WM_W : 1){1'b0}}, wm_q} >= {1'b0, level});

  always_ff @(posedge clk) begin
    if (rst) begin
      wm_q <= '0;
      req  <= 1'b1;
    end else begin
      if (wm_we) wm_q <= wm_wdata;
      req <= at_or_below;
    end
  end

  // R6
  req_track_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (req == ($past(level) <= CNT_W'($past(wm_q)))));
  // R7
  wm_load_chk: assert property (@(posedge clk) disable iff (rst)
    wm_we |=> (wm_q == $past(wm_wdata)));
  // R9
  reset_state_chk: assert property (@(posedge clk) rst |=> (req && wm_q == '0));
endmodule

// File: rtl/tx_wm_fifo.sv
module tx_wm_fifo
  import txf_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int DEPTH  = DEPTH_DEF,
  parameter int WM_W   = WM_W_DEF,
  parameter int CNT_W  = cnt_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flush,
  input  logic              wm_we,
  input  logic [WM_W-1:0]   wm_wdata,
  input  logic              pop_req,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  output logic [CNT_W-1:0]  level,
  output logic [WM_W-1:0]   wm_q,
  output logic              tx_req,
  output logic              ovf
);
  localparam int AW = addr_bits(DEPTH);

  logic          rst_all;
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_waddr, mem_raddr;

  assign rst_all = rst | sw_rst;

  txf_ctrl #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst_all), .push(wr_en), .pop(pop_req), .flush(flush),
    .we(mem_we), .waddr(mem_waddr), .re(mem_re), .raddr(mem_raddr),
    .level(level), .pop_valid(pop_valid), .ovf(ovf)
  );

  txf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
    .re(mem_re), .raddr(mem_raddr), .rdata(pop_data)
  );

  txf_wmark #(.WM_W(WM_W), .CNT_W(CNT_W)) u_wmark (
    .clk(clk), .rst(rst_all), .wm_we(wm_we), .wm_wdata(wm_wdata),
    .level(level), .wm_q(wm_q), .req(tx_req)
  );
endmodule

// File: tb/tx_wm_fifo_tb.sv
module tx_wm_fifo_tb;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1, sw_rst = 1'b0, wr_en = 1'b0, flush = 1'b0;
  logic       wm_we = 1'b0, pop_req = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] wm_wdata = '0;
  logic       pop_valid, tx_req, ovf;
  logic [7:0] pop_data;
  logic [2:0] level;
  logic [1:0] wm_q;

  int checks = 0, errors = 0;
  int mq [DEPTH];
  int mcnt = 0, mwm = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tx_wm_fifo u_dut (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .wr_en(wr_en), .wr_data(wr_data),
    .flush(flush), .wm_we(wm_we), .wm_wdata(wm_wdata), .pop_req(pop_req),
    .pop_valid(pop_valid), .pop_data(pop_data), .level(level), .wm_q(wm_q),
    .tx_req(tx_req), .ovf(ovf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input bit push, input int d, input bit pop, input bit fl,
                      input bit wwe, input int wv, input bit srst);
    int c0, w0, epd;
    bit epv, eovf, ereq;
    string tag;
    c0 = mcnt; w0 = mwm; epd = 0;
    wr_en = push; wr_data = 8'(d); pop_req = pop; flush = fl;
    wm_we = wwe; wm_wdata = 2'(wv); sw_rst = srst;
    if (srst) begin
      mcnt = 0; mwm = 0; epv = 0; eovf = 0; ereq = 1; tag = "R9";
    end else begin
      ereq = (c0 <= w0);
      eovf = push && !fl && c0 == DEPTH;
      epv  = pop && !fl && c0 > 0;
      if (wwe) mwm = wv;
      if (fl) begin
        mcnt = 0; tag = "R8";
      end else begin
        if (epv) begin
          epd = mq[0];
          for (int i = 0; i < DEPTH - 1; i++) mq[i] = mq[i+1];
          mcnt--;
        end
        if (push && c0 < DEPTH) begin
          mq[mcnt] = d; mcnt++;
        end
        if (push && pop && c0 > 0 && c0 < DEPTH) tag = "R5";
        else if (pop && c0 == 0) tag = "R3";
        else if (push && c0 == DEPTH) tag = "R4";
        else if (pop) tag = "R2";
        else tag = "R1";
      end
    end
    @(posedge clk); @(negedge clk);
    cyc++;
    chk({tag, " level"}, int'(level), mcnt);
    chk({tag, " pop_valid"}, int'(pop_valid), int'(epv));
    if (epv) chk("R2 pop_data", int'(pop_data), epd);
    chk({tag, " ovf"}, int'(ovf), int'(eovf));
    chk("R6 tx_req", int'(tx_req), int'(ereq));
    chk("R7 wm_q", int'(wm_q), mwm);
    wr_en = 0; pop_req = 0; flush = 0; wm_we = 0; sw_rst = 0;
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    // R9 chip reset state
    chk("R9 level", int'(level), 0);
    chk("R9 tx_req", int'(tx_req), 1);
    chk("R9 wm_q", int'(wm_q), 0);
    chk("R9 ovf", int'(ovf), 0);
    chk("R9 pop_valid", int'(pop_valid), 0);
    // R3 pop on empty
    step(0, 0, 1, 0, 0, 0, 0);
    // R6/R7 sweep: each threshold against each fill level, one past full
    for (int w = 0; w < 4; w++) begin
      step(0, 0, 0, 0, 1, w, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      for (int k = 0; k <= DEPTH; k++) begin
        step(1, w * 16 + k + 1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
      end
      // R4 full write with pop
      step(1, 8'hEE, 1, 0, 0, 0, 0);
      // R5 simultaneous at partial fill
      step(1, 8'h50 + w, 1, 0, 0, 0, 0);
      for (int k = 0; k <= DEPTH; k++) begin
        step(0, 0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
      end
    end
    // R8 flush beats push and pop
    for (int k = 0; k < DEPTH; k++) step(1, 8'hA0 + k, 0, 0, 0, 0, 0);
    step(1, 8'hBB, 1, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    step(1, 8'hC1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    // R9 software reset with stored words and nonzero threshold
    step(0, 0, 0, 0, 1, 3, 0);
    step(1, 8'h11, 0, 0, 0, 0, 0);
    step(1, 8'h22, 0, 0, 0, 0, 0);
    step(1, 8'h33, 1, 0, 0, 0, 1);
    step(0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule